// File: doc/BRIEF.md
# PCI Base Address Register Bank

This block holds the base address registers of one PCI function and decodes incoming addresses against them. There are seven regions: six standard BARs and one expansion ROM BAR. Parameters fix each region's size (a power of two, or zero when the region is absent) and its type bits. Bit 0 of the type marks an I/O region. The ROM region is always memory space.

Configuration software writes BARs through a config write port that carries an offset, a byte length and data. The block keeps only the bits that size alignment allows, and it flags every write it does not take, so that the ordinary config register file can handle that write. A read port returns the stored BAR at a given offset, which lets software size a region by writing all ones and reading the value back.

Each region's decoded base is derived from the stored BAR and the command register. A lookup port returns a hit flag and the index of the lowest-numbered region whose window holds the address in the requested space.

Top module: `cfg_bar_bank`

## Requirements
- R1: After reset, each present standard BAR holds its type bits zero-extended, the ROM BAR and absent regions hold 0, and with the command register clear every decoded base is 0xFFFFFFFF.
- R2: A write is taken as a BAR write only when its length is 4 and its offset is exactly 0x10, 0x14, 0x18, 0x1C, 0x20, 0x24 (regions 0 to 5) or 0x30 (region 6, the ROM). Any other write raises cfg_wr_pass_o and leaves every BAR unchanged.
- R3: A write to a region whose size is 0 raises cfg_wr_pass_o and stores nothing. A read of that offset returns 0 with cfg_rd_bar_o low.
- R4: A standard BAR write stores the data with the bits below the region size cleared, ORed with the region's 4-bit type.
- R5: A ROM BAR write stores the data with the bits below the region size cleared, except bit 0, which is kept as the ROM decode enable.
- R6: A read at a present region's offset returns its stored value with cfg_rd_bar_o high. Writing all ones and reading back yields the size mask with the type bits (or the ROM enable bit).
- R7: An I/O region is decoded only while command bit 0 is set, and a memory region only while command bit 1 is set. A region that is not decoded reports a base of 0xFFFFFFFF and never hits.
- R8: The ROM region is decoded only when command bit 1 and ROM BAR bit 0 are both set.
- R9: A decoded base is the stored value masked to size alignment. A lookup hits a region when the address lies in [base, base+size-1] and lk_is_io_i equals the region's I/O flag.
- R10: An I/O region whose last address exceeds 0xFFFF is unmapped (base 0xFFFFFFFF, no hit). A memory region whose last address wraps past 2^32 is unmapped.
- R11: When several regions match, hit_idx_o gives the lowest index. With no hit, hit_o is 0 and hit_idx_o is 0.
- R12: Decoded bases and the hit result follow the command and lookup inputs combinationally, and they reflect a BAR write from the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Config write strobe |
| cfg_wr_off_i | input | 8 | Config write byte offset |
| cfg_wr_len_i | input | 3 | Config write length in bytes |
| cfg_wr_data_i | input | 32 | Config write data |
| cfg_wr_pass_o | output | 1 | Write not taken as a BAR write |
| cfg_rd_off_i | input | 8 | Config read byte offset |
| cfg_rd_data_o | output | 32 | Stored BAR at the read offset, else 0 |
| cfg_rd_bar_o | output | 1 | Read offset maps to a present BAR |
| cmd_i | input | 16 | Command register (bit 0 I/O, bit 1 memory) |
| lk_addr_i | input | 32 | Lookup address |
| lk_is_io_i | input | 1 | Lookup is in I/O space |
| hit_o | output | 1 | Some region holds the lookup address |
| hit_idx_o | output | 3 | Lowest matching region index |
| bar_o | output | 224 | Stored BARs, region n at bits 32n+31:32n |
| base_o | output | 224 | Decoded bases, region n at bits 32n+31:32n |

## Verification
The bench uses the following regions:
- Region 0: I/O, 16 bytes.
- Region 1: memory, 4 KiB.
- Region 2: memory, 256 bytes, prefetchable type 0x8.
- Region 3: absent.
- Region 4: I/O, 256 bytes.
- Region 5: memory, 1 MiB.
- ROM: 64 KiB.

The absent region exercises write pass-through and the zero read. The two I/O sizes place windows that end exactly at 0xFFFF and windows that cross it. Regions 1 and 2 overlap with the ROM window, which brings priority ordering and ROM enable gating within reach.

// File: rtl/bar_pkg.sv
`timescale 1ns/1ps
package bar_pkg;
  localparam int NUM_STD     = 6;
  localparam int NUM_REGIONS = NUM_STD + 1;
  localparam int IDX_W       = $clog2(NUM_REGIONS);
  localparam int ROM_IDX     = NUM_STD;
  localparam int DW          = 32;

  localparam logic [7:0] STD_OFF = 8'h10;
  localparam logic [7:0] STD_END = STD_OFF + 8'(4 * NUM_STD);
  localparam logic [7:0] ROM_OFF = 8'h30;

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] idx;
  } bar_sel_t;

  function automatic bar_sel_t decode_off(input logic [7:0] off);
    bar_sel_t s;
    s = '0;
    if (off == ROM_OFF) begin
      s.valid = 1'b1;
      s.idx   = IDX_W'(ROM_IDX);
    end else if (off[1:0] == 2'b00 && off >= STD_OFF && off < STD_END) begin
      s.valid = 1'b1;
      s.idx   = IDX_W'((off - STD_OFF) >> 2);
    end
    return s;
  endfunction
endpackage

// File: rtl/bar_slot.sv
`timescale 1ns/1ps
module bar_slot #(
  parameter logic [31:0] SIZE   = 32'h10,
  parameter logic [3:0]  TYPE   = 4'h1,
  parameter bit          IS_ROM = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  input  logic        io_en_i,
  input  logic        mem_en_i,
  input  logic [31:0] lk_addr_i,
  input  logic        lk_is_io_i,
  output logic [31:0] stored_o,
  output logic [31:0] base_o,
  output logic        match_o
);
  localparam bit          PRESENT  = (SIZE != 32'h0);
  localparam bit          IS_IO    = !IS_ROM && TYPE[0];
  localparam logic [31:0] LOW_MASK = SIZE - 32'h1;
  localparam logic [31:0] RST_VAL  = (!PRESENT || IS_ROM) ? 32'h0 : {28'h0, TYPE};

  logic [31:0] bar_q, wr_val, aligned;
  logic [32:0] last_ext;
  logic        enabled, in_limit, mapped;

  // ROM keeps its enable bit; standard BARs force type bits
  if (IS_ROM) begin : g_rom_wr
    assign wr_val = wr_data_i & (~LOW_MASK | 32'h1);
  end else begin : g_std_wr
    assign wr_val = (wr_data_i & ~LOW_MASK) | {28'h0, TYPE};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  bar_q <= RST_VAL;
    else if (wr_en_i && PRESENT)  bar_q <= wr_val;
  end

  always_comb begin
    aligned  = bar_q & ~LOW_MASK;
    last_ext = {1'b0, aligned} + {1'b0, LOW_MASK};
    if (IS_IO) enabled = PRESENT && io_en_i;
    else       enabled = PRESENT && mem_en_i && (!IS_ROM || bar_q[0]);
    if (IS_IO) in_limit = (last_ext <= 33'h0_0000_FFFF);
    else       in_limit = !last_ext[32];
    mapped   = enabled && in_limit;
    base_o   = mapped ? aligned : '1;
    match_o  = mapped && (lk_is_io_i == IS_IO) && ((lk_addr_i & ~LOW_MASK) == aligned);
  end

  assign stored_o = bar_q;
endmodule

// File: rtl/bar_pick.sv
`timescale 1ns/1ps
module bar_pick #(
  parameter int N     = 7,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     match_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    hit_o = |match_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/cfg_bar_bank.sv
`timescale 1ns/1ps
module cfg_bar_bank
  import bar_pkg::*;
#(
  parameter logic [NUM_REGIONS-1:0][31:0] REGION_SIZE =
    {32'h0001_0000, 32'h0010_0000, 32'h0000_0100, 32'h0, 32'h0000_0100, 32'h0000_1000, 32'h0000_0010},
  parameter logic [NUM_REGIONS-1:0][3:0] REGION_TYPE =
    {4'h0, 4'h0, 4'h1, 4'h0, 4'h8, 4'h0, 4'h1}
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_wr_i,
  input  logic [7:0]                cfg_wr_off_i,
  input  logic [2:0]                cfg_wr_len_i,
  input  logic [31:0]               cfg_wr_data_i,
  output logic                      cfg_wr_pass_o,
  input  logic [7:0]                cfg_rd_off_i,
  output logic [31:0]               cfg_rd_data_o,
  output logic                      cfg_rd_bar_o,
  input  logic [15:0]               cmd_i,
  input  logic [31:0]               lk_addr_i,
  input  logic                      lk_is_io_i,
  output logic                      hit_o,
  output logic [IDX_W-1:0]          hit_idx_o,
  output logic [NUM_REGIONS*DW-1:0] bar_o,
  output logic [NUM_REGIONS*DW-1:0] base_o
);
  bar_sel_t                         wr_sel, rd_sel;
  logic                             bar_wr;
  logic [NUM_REGIONS-1:0]           present;
  logic [NUM_REGIONS-1:0]           match;
  logic [NUM_REGIONS-1:0][DW-1:0]   stored_w, base_w;
  logic                             unused_cmd;

  assign unused_cmd = ^cmd_i[15:2];

  always_comb begin
    wr_sel        = decode_off(cfg_wr_off_i);
    bar_wr        = cfg_wr_i && (cfg_wr_len_i == 3'd4) && wr_sel.valid && present[wr_sel.idx];
    cfg_wr_pass_o = cfg_wr_i && !bar_wr;
  end

  always_comb begin
    rd_sel        = decode_off(cfg_rd_off_i);
    cfg_rd_bar_o  = rd_sel.valid && present[rd_sel.idx];
    cfg_rd_data_o = cfg_rd_bar_o ? stored_w[rd_sel.idx] : '0;
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_slot
    assign present[g] = (REGION_SIZE[g] != 32'h0);
    bar_slot #(
      .SIZE   (REGION_SIZE[g]),
      .TYPE   (REGION_TYPE[g]),
      .IS_ROM (g == ROM_IDX)
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (bar_wr && (wr_sel.idx == IDX_W'(g))),
      .wr_data_i  (cfg_wr_data_i),
      .io_en_i    (cmd_i[0]),
      .mem_en_i   (cmd_i[1]),
      .lk_addr_i  (lk_addr_i),
      .lk_is_io_i (lk_is_io_i),
      .stored_o   (stored_w[g]),
      .base_o     (base_w[g]),
      .match_o    (match[g])
    );
  end

  bar_pick #(.N(NUM_REGIONS), .IDX_W(IDX_W)) u_pick (
    .match_i (match),
    .hit_o   (hit_o),
    .idx_o   (hit_idx_o)
  );

  assign bar_o  = stored_w;
  assign base_o = base_w;
endmodule

// File: rtl/cfg_bar_bank_chk.sv
`timescale 1ns/1ps
module cfg_bar_bank_chk
  import bar_pkg::*;
#(
  parameter logic [NUM_REGIONS-1:0][31:0] REGION_SIZE = '0,
  parameter logic [NUM_REGIONS-1:0][3:0]  REGION_TYPE = '0
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [1:0]                cmd_en_i,
  input logic [31:0]               lk_addr_i,
  input logic                      hit_o,
  input logic [IDX_W-1:0]          hit_idx_o,
  input logic                      cfg_wr_pass_o,
  input logic [NUM_REGIONS*DW-1:0] bar_o,
  input logic [NUM_REGIONS*DW-1:0] base_o
);
  logic [NUM_REGIONS-1:0][DW-1:0] base_v, bar_v;
  logic [DW-1:0] hit_base, hit_mask;

  assign base_v   = base_o;
  assign bar_v    = bar_o;
  assign hit_base = base_v[hit_idx_o];
  assign hit_mask = REGION_SIZE[hit_idx_o] - 32'h1;

  assert_hit_in_window_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (hit_base != '1) && ((lk_addr_i & ~hit_mask) == hit_base));

  assert_cmd_off_no_decode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_en_i == 2'b00) |-> (!hit_o && (base_o == '1)));

  assert_rom_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bar_v[ROM_IDX][0] |-> (base_v[ROM_IDX] == '1));

  assert_pass_keeps_bars_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_pass_o |=> $stable(bar_o));

  for (genvar g = 0; g < NUM_STD; g++) begin : g_io
    if (REGION_SIZE[g] != 32'h0 && REGION_TYPE[g][0]) begin : g_lim
      assert_io_window_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (base_v[g] != '1) |-> (({1'b0, base_v[g]} + {1'b0, REGION_SIZE[g] - 32'h1}) <= 33'h0_0000_FFFF));
    end
  end
endmodule

bind cfg_bar_bank cfg_bar_bank_chk #(
  .REGION_SIZE (REGION_SIZE),
  .REGION_TYPE (REGION_TYPE)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_en_i      (cmd_i[1:0]),
  .lk_addr_i     (lk_addr_i),
  .hit_o         (hit_o),
  .hit_idx_o     (hit_idx_o),
  .cfg_wr_pass_o (cfg_wr_pass_o),
  .bar_o         (bar_o),
  .base_o        (base_o)
);

// File: tb/cfg_bar_bank_bench.sv
`timescale 1ns/1ps
module cfg_bar_bank_bench;
  localparam logic [6:0][31:0] P_SIZE =
    {32'h0001_0000, 32'h0010_0000, 32'h0000_0100, 32'h0, 32'h0000_0100, 32'h0000_1000, 32'h0000_0010};
  localparam logic [6:0][3:0] P_TYPE = {4'h0, 4'h0, 4'h1, 4'h0, 4'h8, 4'h0, 4'h1};
  localparam logic [31:0] SZ [7] = '{32'h10, 32'h1000, 32'h100, 32'h0, 32'h100, 32'h100000, 32'h10000};
  localparam logic [3:0]  TY [7] = '{4'h1, 4'h0, 4'h8, 4'h0, 4'h1, 4'h0, 4'h0};
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0; logic [7:0] wr_off = '0; logic [2:0] wr_len = '0; logic [31:0] wr_data = '0;
  logic [7:0] rd_off = '0; logic [15:0] cmd = '0; logic [31:0] lk_addr = '0; logic lk_io = 1'b0;
  logic wr_pass, rd_bar, hit; logic [31:0] rd_data; logic [2:0] hit_idx;
  logic [223:0] bar_flat, base_flat;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] m_bar [7];

  always #4 clk = ~clk;

  cfg_bar_bank #(.REGION_SIZE(P_SIZE), .REGION_TYPE(P_TYPE)) u_cfg_bar_bank (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_wr_off_i(wr_off), .cfg_wr_len_i(wr_len),
    .cfg_wr_data_i(wr_data), .cfg_wr_pass_o(wr_pass), .cfg_rd_off_i(rd_off), .cfg_rd_data_o(rd_data),
    .cfg_rd_bar_o(rd_bar), .cmd_i(cmd), .lk_addr_i(lk_addr), .lk_is_io_i(lk_io), .hit_o(hit),
    .hit_idx_o(hit_idx), .bar_o(bar_flat), .base_o(base_flat));

  function automatic int off_idx(input logic [7:0] off);
    if (off == 8'h30) return 6;
    if (off >= 8'h10 && off <= 8'h24 && off % 4 == 0) return (int'(off) - 16) / 4;
    return -1;
  endfunction

  function automatic bit is_io(input int i);
    return (i < 6) && TY[i][0];
  endfunction

  function automatic logic [31:0] m_base(input int i);
    longint unsigned sz, b;
    sz = longint'(SZ[i]);
    if (sz == 0) return ONES;
    if (is_io(i) && !cmd[0]) return ONES;
    if (!is_io(i) && !cmd[1]) return ONES;
    if (i == 6 && !m_bar[6][0]) return ONES;
    b = longint'(m_bar[i]) & ~(sz - 1);
    if (is_io(i) && (b + sz - 1) > 64'hFFFF) return ONES;
    if ((b + sz - 1) > 64'hFFFF_FFFF) return ONES;
    return b[31:0];
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    bit got; int gi; int ri; longint unsigned b, a;
    got = 0; gi = 0;
    for (int i = 0; i < 7; i++) begin
      chk(tag, $sformatf("bar%0d", i), bar_flat[32*i +: 32], m_bar[i]);
      chk(tag, $sformatf("base%0d", i), base_flat[32*i +: 32], m_base(i));
      b = longint'(m_base(i)); a = longint'(lk_addr);
      if (!got && m_base(i) != ONES && is_io(i) == lk_io && a >= b && a <= b + longint'(SZ[i]) - 1) begin
        got = 1; gi = i;
      end
    end
    chk(tag, "hit", {31'h0, hit}, {31'h0, got});
    chk(tag, "hit_idx", {29'h0, hit_idx}, 32'(gi));
    ri = off_idx(rd_off);
    if (ri >= 0 && SZ[ri] != 0) begin
      chk(tag, "rd_bar", {31'h0, rd_bar}, 32'h1);
      chk(tag, "rd_data", rd_data, m_bar[ri]);
    end else begin
      chk(tag, "rd_bar", {31'h0, rd_bar}, 32'h0);
      chk(tag, "rd_data", rd_data, 32'h0);
    end
    ri = off_idx(wr_off);
    chk(tag, "wr_pass", {31'h0, wr_pass},
        {31'h0, cfg_wr && !(wr_len == 3'd4 && ri >= 0 && SZ[ri] != 0)});
  endtask

  task automatic model_update();
    int i;
    i = off_idx(wr_off);
    if (cfg_wr && wr_len == 3'd4 && i >= 0 && SZ[i] != 0) begin
      if (i == 6) m_bar[i] = wr_data & (~(SZ[i] - 32'h1) | 32'h1);
      else        m_bar[i] = (wr_data & ~(SZ[i] - 32'h1)) | {28'h0, TY[i]};
    end
  endtask

  task automatic tick(input string tag);
    #2;
    compare_all(tag);
    @(posedge clk);
    if (rst_n) model_update();
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] off, input logic [2:0] len, input logic [31:0] d, input string tag);
    cfg_wr = 1'b1; wr_off = off; wr_len = len; wr_data = d;
    tick(tag);
  endtask

  task automatic look(input logic [31:0] a, input logic io, input string tag, input logic eh, input logic [2:0] ei);
    lk_addr = a; lk_io = io;
    #1;
    chk(tag, "hit(direct)", {31'h0, hit}, {31'h0, eh});
    chk(tag, "idx(direct)", {29'h0, hit_idx}, {29'h0, ei});
    tick(tag);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) m_bar[i] = (SZ[i] == 0 || i == 6) ? 32'h0 : {28'h0, TY[i]};
    @(negedge clk);
    tick("R1");
    rst_n = 1'b1;
    tick("R1");
    chk("R1", "bar0 reset", bar_flat[31:0], 32'h1);
    chk("R1", "base all ones", base_flat[63:32], ONES);

    // R6: size discovery by writing all ones
    for (int i = 0; i < 7; i++) begin
      logic [7:0] o;
      o = (i == 6) ? 8'h30 : 8'(8'h10 + 4 * i);
      wr(o, 3'd4, ONES, "R6");
      rd_off = o;
      tick("R6");
    end
    rd_off = 8'h10; #1; chk("R6", "bar0 mask", rd_data, 32'hFFFF_FFF1);
    rd_off = 8'h18; #1; chk("R6", "bar2 mask", rd_data, 32'hFFFF_FF08);
    rd_off = 8'h30; #1; chk("R6", "rom mask", rd_data, 32'hFFFF_0001);
    tick("R6");

    // R4 / R5
    wr(8'h18, 3'd4, 32'h1234_5677, "R4"); rd_off = 8'h18; #1;
    chk("R4", "bar2 store", rd_data, 32'h1234_5608); tick("R4");
    wr(8'h30, 3'd4, 32'h1234_5678, "R5"); rd_off = 8'h30; #1;
    chk("R5", "rom store", rd_data, 32'h1234_0000); tick("R5");
    wr(8'h30, 3'd4, 32'hABCD_1235, "R5"); #1;
    chk("R5", "rom enable kept", rd_data, 32'hABCD_0001); tick("R5");

    // R2: writes that are not BAR writes
    wr(8'h10, 3'd2, 32'h0, "R2");
    wr(8'h12, 3'd4, 32'h0, "R2");
    wr(8'h28, 3'd4, 32'h0, "R2");
    wr(8'h2C, 3'd4, 32'h0, "R2");
    wr(8'h34, 3'd4, 32'h0, "R2");
    wr(8'h0C, 3'd4, 32'h0, "R2");
    wr(8'h30, 3'd1, 32'h0, "R2");
    cfg_wr = 1'b1; wr_off = 8'h14; wr_len = 3'd4; wr_data = 32'h2000_0000; #1;
    chk("R2", "valid write not passed", {31'h0, wr_pass}, 32'h0);
    tick("R2");

    // R3: absent region
    cfg_wr = 1'b1; wr_off = 8'h1C; wr_len = 3'd4; wr_data = 32'h5555_0000; #1;
    chk("R3", "absent passes", {31'h0, wr_pass}, 32'h1);
    tick("R3");
    rd_off = 8'h1C; #1;
    chk("R3", "absent read", {rd_data[30:0], rd_bar}, 32'h0);
    tick("R3");

    // R7: command gating
    wr(8'h10, 3'd4, 32'h0000_1000, "R7");
    cmd = 16'h0000; look(32'h0000_1008, 1'b1, "R7", 1'b0, 3'd0);
    cmd = 16'h0001; look(32'h0000_1008, 1'b1, "R7", 1'b1, 3'd0);
    look(32'h2000_0004, 1'b0, "R7", 1'b0, 3'd0);
    cmd = 16'h0002; look(32'h2000_0004, 1'b0, "R7", 1'b1, 3'd1);
    look(32'h0000_1008, 1'b1, "R7", 1'b0, 3'd0);

    // R9: window edges and space match
    cmd = 16'h0003;
    look(32'h2000_0FFF, 1'b0, "R9", 1'b1, 3'd1);
    look(32'h2000_1000, 1'b0, "R9", 1'b0, 3'd0);
    look(32'h1FFF_FFFF, 1'b0, "R9", 1'b0, 3'd0);
    look(32'h0000_100F, 1'b1, "R9", 1'b1, 3'd0);
    look(32'h0000_1010, 1'b1, "R9", 1'b0, 3'd0);
    look(32'h2000_0000, 1'b1, "R9", 1'b0, 3'd0);

    // R8: ROM enable bit
    wr(8'h30, 3'd4, 32'h3000_0000, "R8");
    look(32'h3000_0010, 1'b0, "R8", 1'b0, 3'd0);
    wr(8'h30, 3'd4, 32'h3000_0001, "R8");
    look(32'h3000_0010, 1'b0, "R8", 1'b1, 3'd6);
    cmd = 16'h0001;
    look(32'h3000_0010, 1'b0, "R8", 1'b0, 3'd0);
    cmd = 16'h0003;

    // R10: I/O 64K limit
    wr(8'h20, 3'd4, 32'h0000_FF00, "R10");
    look(32'h0000_FFFF, 1'b1, "R10", 1'b1, 3'd4);
    wr(8'h20, 3'd4, 32'h0001_0000, "R10");
    look(32'h0001_0000, 1'b1, "R10", 1'b0, 3'd0);
    wr(8'h20, 3'd4, 32'hFFFF_FF00, "R10");
    look(32'hFFFF_FF00, 1'b1, "R10", 1'b0, 3'd0);
    wr(8'h10, 3'd4, 32'h0000_FFF0, "R10");
    look(32'h0000_FFF8, 1'b1, "R10", 1'b1, 3'd0);

    // R11: overlap priority
    wr(8'h14, 3'd4, 32'h5000_0000, "R11");
    wr(8'h18, 3'd4, 32'h5000_0000, "R11");
    wr(8'h30, 3'd4, 32'h5000_0001, "R11");
    look(32'h5000_0010, 1'b0, "R11", 1'b1, 3'd1);
    look(32'h5000_0100, 1'b0, "R11", 1'b1, 3'd1);
    look(32'h5000_2000, 1'b0, "R11", 1'b1, 3'd6);
    wr(8'h14, 3'd4, 32'h6000_0000, "R11");
    look(32'h5000_0010, 1'b0, "R11", 1'b1, 3'd2);

    // R12: result follows the storing edge and command without delay
    lk_addr = 32'h4000_0000; lk_io = 1'b0;
    cfg_wr = 1'b1; wr_off = 8'h24; wr_len = 3'd4; wr_data = 32'h4000_0000; #1;
    chk("R12", "hit before store", {31'h0, hit}, 32'h0);
    tick("R12");
    #1;
    chk("R12", "hit after store", {29'h0, hit_idx, hit}, {29'h0, 3'd5, 1'b1});
    chk("R12", "base5", base_flat[191:160], 32'h4000_0000);
    cmd = 16'h0001; #1;
    chk("R12", "cmd drop", {31'h0, hit}, 32'h0);
    tick("R12");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule